// File: doc/BRIEF.md
# Two-Operand ALU with Bit-Serial Shifter

This block is the arithmetic and logic unit of a small 16-bit processor whose instructions name a source operand and a destination operand. On a start pulse it takes a 5-bit opcode, the source value (a register or an immediate that has already been resolved), the destination value and the current carry flag. It returns the new destination value, a write strobe for the destination, a flag-update strobe and the three status flags.

Arithmetic and logical operations complete one cycle after start. Shifts and rotates move the destination one bit per cycle. The low four bits of the source set how many steps to take, so these operations hold `busy` high while more steps remain. Every accepted operation ends with a one-cycle `done` pulse. The register file, operand fetch, addressing modes and memory traffic sit outside this block.

Top module: `aluCore`

## Requirements
- R1: Opcode 0x05 yields destination plus source, and opcode 0x06 yields destination plus source plus `carryIn`. Both write the destination, and the carry out of bit 15 becomes the carry flag.
- R2: Opcode 0x07 yields destination minus source and writes the destination. The carry flag is 1 when no borrow occurs, that is when destination >= source unsigned.
- R3: Opcode 0x08 performs the R2 subtraction and updates the flags, but `writeEn` stays low.
- R4: Opcodes 0x0D, 0x0E and 0x0F give source AND, OR and XOR destination. Opcode 0x10 gives the inverse of the destination. All four write the destination and clear the carry flag.
- R5: `flags` bit 0 is carry, bit 1 is zero (result equals 0) and bit 2 is negative (result bit 15). The flags are valid while `done` is high.
- R6: Opcode 0x09 shifts right and opcode 0x0A shifts left. Each step brings in a 0 and moves the bit shifted out into carry.
- R7: Opcode 0x0B rotates right through carry and opcode 0x0C rotates left through carry. Each step moves the old carry into the vacated end and the bit shifted out into carry.
- R8: The step count of a shift or rotate is source bits 3:0 (n). `done` rises n clock edges after the start edge, and `busy` is high in the cycles between. A non-shift operation raises `done` one edge after start.
- R9: A shift or rotate with a step count of 0 finishes one edge after start. The result equals the destination and the carry flag equals `carryIn`.
- R10: An opcode outside 0x05..0x10 still produces a `done` pulse, but `writeEn` and `flagWe` stay low.
- R11: A start pulse while `busy` is high is ignored. The running operation's result and timing do not change.
- R12: After reset, `busy`, `done`, `writeEn` and `flagWe` are low.
- R13: `writeEn` and `flagWe` are high only in the cycle where `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation with the current operands |
| opcode | input | 5 | Operation select |
| srcVal | input | 16 | Source operand; bits 3:0 give the shift step count |
| dstVal | input | 16 | Destination operand |
| carryIn | input | 1 | Current carry flag |
| busy | output | 1 | Shift or rotate still has steps left |
| done | output | 1 | One-cycle completion pulse |
| result | output | 16 | New destination value |
| writeEn | output | 1 | Write result to destination |
| flagWe | output | 1 | Update status flags |
| flags | output | 3 | {negative, zero, carry} |

## Verification
If the step counter is corrupted, `done` arrives on the wrong edge, `busy` ends too early or too late, or a rotate travels the wrong distance. These faults show up as a cycle count or a shifted pattern that differs from the expected value within sixteen cycles of start. A corrupted working register or carry bit shows up in `result` or `flags` in the same `done` cycle. A lost opcode class shows up as a `writeEn` or `flagWe` that is wrongly high or low on the very first `done` pulse.

// File: rtl/aluPkg.sv
package aluPkg;
  localparam logic [4:0] OP_ADD  = 5'h05;
  localparam logic [4:0] OP_ADDC = 5'h06;
  localparam logic [4:0] OP_SUB  = 5'h07;
  localparam logic [4:0] OP_CMP  = 5'h08;
  localparam logic [4:0] OP_SHR  = 5'h09;
  localparam logic [4:0] OP_SHL  = 5'h0A;
  localparam logic [4:0] OP_RRC  = 5'h0B;
  localparam logic [4:0] OP_RLC  = 5'h0C;
  localparam logic [4:0] OP_AND  = 5'h0D;
  localparam logic [4:0] OP_OR   = 5'h0E;
  localparam logic [4:0] OP_XOR  = 5'h0F;
  localparam logic [4:0] OP_NOT  = 5'h10;

  typedef struct packed {
    logic takeSingle;
    logic loadShift;
    logic stepShift;
  } aluCtrlT;

  function automatic logic isShiftOp(input logic [4:0] op);
    return (op >= OP_SHR) && (op <= OP_RLC);
  endfunction

  function automatic logic isAluOp(input logic [4:0] op);
    return (op >= OP_ADD) && (op <= OP_NOT);
  endfunction

  function automatic logic writesDest(input logic [4:0] op);
    return isAluOp(op) && (op != OP_CMP);
  endfunction
endpackage

// File: rtl/aluControl.sv
module aluControl
  import aluPkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [4:0]       opcode,
  input  logic [CNT_W-1:0] count,
  output aluCtrlT          ctrl,
  output logic             busy,
  output logic             done
);
  logic [CNT_W-1:0] cntQ;
  logic busyQ;
  logic doneQ;
  logic accept;

  assign accept = start && !busyQ;
  assign busy   = busyQ;
  assign done   = doneQ;

  always_comb begin
    ctrl = '0;
    if (accept) begin
      if (isShiftOp(opcode)) begin
        ctrl.loadShift = 1'b1;
        ctrl.stepShift = (count != '0);
      end else begin
        ctrl.takeSingle = 1'b1;
      end
    end else if (busyQ) begin
      ctrl.stepShift = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntQ  <= '0;
      busyQ <= 1'b0;
      doneQ <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      if (accept) begin
        if (isShiftOp(opcode) && (count > CNT_W'(1))) begin
          busyQ <= 1'b1;
          cntQ  <= count - CNT_W'(1);
        end else begin
          doneQ <= 1'b1;
        end
      end else if (busyQ) begin
        cntQ <= cntQ - CNT_W'(1);
        if (cntQ == CNT_W'(1)) begin
          busyQ <= 1'b0;
          doneQ <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/aluDatapath.sv
module aluDatapath
  import aluPkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  aluCtrlT           ctrl,
  input  logic [4:0]        opcode,
  input  logic [DATA_W-1:0] srcVal,
  input  logic [DATA_W-1:0] dstVal,
  input  logic              carryIn,
  output logic [DATA_W-1:0] resQ,
  output logic              carryQ,
  output logic              weQ,
  output logic              feQ
);
  logic [4:0]        shOpQ;
  logic [4:0]        stepOp;
  logic [DATA_W-1:0] stepBase;
  logic              stepCin;
  logic [DATA_W-1:0] stepRes;
  logic              stepC;
  logic [DATA_W:0]   wide;
  logic [DATA_W-1:0] singleRes;
  logic              singleC;

  assign stepOp   = ctrl.loadShift ? opcode  : shOpQ;
  assign stepBase = ctrl.loadShift ? dstVal  : resQ;
  assign stepCin  = ctrl.loadShift ? carryIn : carryQ;

  always_comb begin
    stepRes = stepBase;
    stepC   = stepCin;
    case (stepOp)
      OP_SHR: begin
        stepRes = {1'b0, stepBase[DATA_W-1:1]};
        stepC   = stepBase[0];
      end
      OP_SHL: begin
        stepRes = {stepBase[DATA_W-2:0], 1'b0};
        stepC   = stepBase[DATA_W-1];
      end
      OP_RRC: begin
        stepRes = {stepCin, stepBase[DATA_W-1:1]};
        stepC   = stepBase[0];
      end
      OP_RLC: begin
        stepRes = {stepBase[DATA_W-2:0], stepCin};
        stepC   = stepBase[DATA_W-1];
      end
      default: ;
    endcase
  end

  always_comb begin
    wide      = '0;
    singleRes = dstVal;
    singleC   = carryIn;
    case (opcode)
      OP_ADD, OP_ADDC: begin
        wide = {1'b0, dstVal} + {1'b0, srcVal}
             + {{DATA_W{1'b0}}, (opcode == OP_ADDC) && carryIn};
        singleRes = wide[DATA_W-1:0];
        singleC   = wide[DATA_W];
      end
      OP_SUB, OP_CMP: begin
        wide      = {1'b0, dstVal} - {1'b0, srcVal};
        singleRes = wide[DATA_W-1:0];
        singleC   = !wide[DATA_W];
      end
      OP_AND: begin singleRes = srcVal & dstVal; singleC = 1'b0; end
      OP_OR:  begin singleRes = srcVal | dstVal; singleC = 1'b0; end
      OP_XOR: begin singleRes = srcVal ^ dstVal; singleC = 1'b0; end
      OP_NOT: begin singleRes = ~dstVal;         singleC = 1'b0; end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resQ   <= '0;
      carryQ <= 1'b0;
      weQ    <= 1'b0;
      feQ    <= 1'b0;
      shOpQ  <= '0;
    end else if (ctrl.takeSingle) begin
      resQ   <= singleRes;
      carryQ <= singleC;
      weQ    <= writesDest(opcode);
      feQ    <= isAluOp(opcode);
    end else if (ctrl.loadShift) begin
      shOpQ  <= opcode;
      weQ    <= 1'b1;
      feQ    <= 1'b1;
      resQ   <= ctrl.stepShift ? stepRes : dstVal;
      carryQ <= ctrl.stepShift ? stepC   : carryIn;
    end else if (ctrl.stepShift) begin
      resQ   <= stepRes;
      carryQ <= stepC;
    end
  end
endmodule

// File: rtl/aluCore.sv
module aluCore
  import aluPkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [4:0]        opcode,
  input  logic [DATA_W-1:0] srcVal,
  input  logic [DATA_W-1:0] dstVal,
  input  logic              carryIn,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] result,
  output logic              writeEn,
  output logic              flagWe,
  output logic [2:0]        flags
);
  localparam int CNT_W = $clog2(DATA_W);

  aluCtrlT ctrl;
  logic    carryQ;
  logic    weQ;
  logic    feQ;

  aluControl #(.CNT_W(CNT_W)) ctrlUnit (
    .clk(clk), .rstN(rstN), .start(start), .opcode(opcode),
    .count(srcVal[CNT_W-1:0]), .ctrl(ctrl), .busy(busy), .done(done)
  );

  aluDatapath #(.DATA_W(DATA_W)) dataUnit (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .opcode(opcode),
    .srcVal(srcVal), .dstVal(dstVal), .carryIn(carryIn),
    .resQ(result), .carryQ(carryQ), .weQ(weQ), .feQ(feQ)
  );

  assign writeEn = done && weQ;
  assign flagWe  = done && feQ;
  assign flags   = {result[DATA_W-1], result == '0, carryQ};
endmodule

// File: rtl/aluChecker.sv
module aluChecker
  import aluPkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic [4:0]        opcode,
  input logic [DATA_W-1:0] srcVal,
  input logic [DATA_W-1:0] dstVal,
  input logic              busy,
  input logic              done,
  input logic [DATA_W-1:0] result,
  input logic              writeEn,
  input logic              flagWe
);
  // R13
  write_needs_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    (writeEn || flagWe) |-> done);

  // R8
  busy_excludes_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(busy && done));

  // R8
  busy_ends_in_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> (busy || done));

  // R3
  compare_no_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy && opcode == OP_CMP) |=> (done && !writeEn && flagWe));

  // R10
  foreign_op_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy && !isAluOp(opcode)) |=> (done && !writeEn && !flagWe));

  // R9
  zero_count_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy && isShiftOp(opcode) && srcVal[CNT_W-1:0] == '0)
      |=> (done && result == $past(dstVal)));
endmodule

bind aluCore aluChecker #(.DATA_W(DATA_W), .CNT_W(CNT_W)) aluCheck (
  .clk(clk), .rstN(rstN), .start(start), .opcode(opcode),
  .srcVal(srcVal), .dstVal(dstVal), .busy(busy), .done(done),
  .result(result), .writeEn(writeEn), .flagWe(flagWe)
);

// File: tb/aluCore_test.sv
module aluCore_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [4:0]  opcode = '0;
  logic [15:0] srcVal = '0;
  logic [15:0] dstVal = '0;
  logic        carryIn = 1'b0;
  logic        busy, done, writeEn, flagWe;
  logic [15:0] result;
  logic [2:0]  flags;
  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  aluCore uut (
    .clk(clk), .rstN(rstN), .start(start), .opcode(opcode),
    .srcVal(srcVal), .dstVal(dstVal), .carryIn(carryIn),
    .busy(busy), .done(done), .result(result),
    .writeEn(writeEn), .flagWe(flagWe), .flags(flags)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // Independent reference for one operation.
  task automatic model(input logic [4:0] op, input logic [15:0] s,
                       input logic [15:0] d, input logic ci,
                       output logic [15:0] r, output logic c,
                       output bit we, output bit fe, output int lat);
    int n;
    r = d; c = ci; we = 1; fe = 1; lat = 1;
    n = s % 16;
    case (op)
      5'h05: {c, r} = 17'(d) + 17'(s);
      5'h06: {c, r} = 17'(d) + 17'(s) + 17'(ci);
      5'h07, 5'h08: begin
        r = d - s; c = (d >= s);
        if (op == 5'h08) we = 0;
      end
      5'h0D: begin r = s & d; c = 0; end
      5'h0E: begin r = s | d; c = 0; end
      5'h0F: begin r = s ^ d; c = 0; end
      5'h10: begin r = ~d;    c = 0; end
      5'h09, 5'h0A, 5'h0B, 5'h0C: begin
        lat = (n == 0) ? 1 : n;
        for (int k = 0; k < n; k++) begin
          logic oc;
          if (op == 5'h09 || op == 5'h0B) begin
            oc = r[0];
            r = {(op == 5'h0B) ? c : 1'b0, r[15:1]};
          end else begin
            oc = r[15];
            r = {r[14:0], (op == 5'h0C) ? c : 1'b0};
          end
          c = oc;
        end
      end
      default: begin we = 0; fe = 0; end
    endcase
  endtask

  task automatic runOp(input logic [4:0] op, input logic [15:0] s,
                       input logic [15:0] d, input logic ci, input string req);
    logic [15:0] er; logic ec; bit ewe, efe; int lat; int cyc;
    model(op, s, d, ci, er, ec, ewe, efe, lat);
    @(negedge clk);
    start = 1; opcode = op; srcVal = s; dstVal = d; carryIn = ci;
    @(negedge clk);
    start = 0;
    cyc = 1;
    while (!done && cyc < 40) begin
      chk(busy == 1, req, "busy while stepping", busy, 1);
      @(negedge clk);
      cyc++;
    end
    chk(cyc == lat, req, "cycles to done", cyc, lat);
    chk(busy == 0, req, "busy at done", busy, 0);
    chk(writeEn == ewe, req, "writeEn", writeEn, ewe);
    chk(flagWe == efe, req, "flagWe", flagWe, efe);
    if (ewe) chk(result == er, req, "result", result, er);
    if (efe) chk(flags == {er[15], er == 0, ec}, {req, " R5"}, "flags",
                 flags, {er[15], er == 0, ec});
    @(negedge clk);
    chk(!done && !writeEn && !flagWe, "R13", "strobes after done",
        {done, writeEn, flagWe}, 0);
  endtask

  task automatic testReset;
    rstN = 0;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !writeEn && !flagWe, "R12", "outputs in reset",
        {busy, done, writeEn, flagWe}, 0);
    rstN = 1;
    @(negedge clk);
    chk(!busy && !done, "R12", "idle after reset", {busy, done}, 0);
  endtask

  task automatic testArith;
    runOp(5'h05, 16'h0001, 16'hFFFF, 1'b0, "R1");
    runOp(5'h05, 16'h1111, 16'h1234, 1'b1, "R1");
    runOp(5'h06, 16'h0000, 16'h7FFF, 1'b1, "R1");
    runOp(5'h06, 16'h0001, 16'h0002, 1'b0, "R1");
  endtask

  task automatic testSub;
    runOp(5'h07, 16'h0003, 16'h0005, 1'b0, "R2");
    runOp(5'h07, 16'h0005, 16'h0003, 1'b1, "R2");
    runOp(5'h08, 16'h4321, 16'h4321, 1'b0, "R3");
    runOp(5'h08, 16'h0009, 16'h0001, 1'b1, "R3");
  endtask

  task automatic testLogic;
    runOp(5'h0D, 16'hF0F0, 16'h3C3C, 1'b1, "R4");
    runOp(5'h0E, 16'h8000, 16'h0001, 1'b1, "R4");
    runOp(5'h0F, 16'hAAAA, 16'hAAAA, 1'b1, "R4");
    runOp(5'h10, 16'h1234, 16'h00FF, 1'b1, "R4");
  endtask

  task automatic testShift;
    runOp(5'h09, 16'h0001, 16'h8001, 1'b0, "R6");
    runOp(5'h0A, 16'h0003, 16'h8001, 1'b1, "R6");
    runOp(5'h09, 16'h000F, 16'hFFFF, 1'b1, "R6 R8");
    runOp(5'h0B, 16'h0005, 16'h0001, 1'b0, "R7");
    runOp(5'h0C, 16'h000F, 16'h8000, 1'b1, "R7 R8");
    runOp(5'h0C, 16'hFFF2, 16'hC001, 1'b0, "R7 R8");
  endtask

  task automatic testZeroCount;
    runOp(5'h0A, 16'h0010, 16'h8421, 1'b1, "R9");
    runOp(5'h0B, 16'h0000, 16'h0000, 1'b0, "R9");
  endtask

  task automatic testForeign;
    runOp(5'h01, 16'h1111, 16'h2222, 1'b1, "R10");
    runOp(5'h11, 16'h0003, 16'h2222, 1'b0, "R10");
    runOp(5'h1F, 16'h0000, 16'h0000, 1'b0, "R10");
    runOp(5'h04, 16'h0005, 16'h0000, 1'b0, "R10");
  endtask

  task automatic testBusyStart;
    int cyc;
    @(negedge clk);
    start = 1; opcode = 5'h09; srcVal = 16'h0006; dstVal = 16'hFFFF; carryIn = 0;
    @(negedge clk);
    chk(busy == 1, "R11", "busy after shift start", busy, 1);
    opcode = 5'h05; srcVal = 16'h0001; dstVal = 16'h0000; carryIn = 1;
    @(negedge clk);
    start = 0;
    cyc = 2;
    while (!done && cyc < 40) begin
      @(negedge clk);
      cyc++;
    end
    chk(cyc == 6, "R11", "cycles unchanged", cyc, 6);
    chk(result == 16'h03FF, "R11", "result unchanged", result, 16'h03FF);
    chk(flags == 3'b001, "R11", "flags unchanged", flags, 3'b001);
    @(negedge clk);
    chk(!done, "R11", "no second done", done, 0);
  endtask

  initial begin
    fork
      begin
        testReset;
        testArith;
        testSub;
        testLogic;
        testShift;
        testZeroCount;
        testForeign;
        testBusyStart;
        finished = 1;
      end
      begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
          checks++;
          fails++;
          $display("FAIL watchdog: actual hung expected finished");
        end
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule